// File: doc/BRIEF.md
# Dual-Class Physical Register Free List

This block keeps the set of unused physical registers for a register renamer that handles two register classes, integer and floating-point. The two classes share one physical index space. The integer indices come first, from 0 up to `INT_PHYS-1`, and the floating-point indices follow straight after them. Each class has its own pool, and each pool is a circular queue that hands out the register that has waited longest.

The rename stage raises a per-class allocate request. It reads the index at the head of that class's pool in the same cycle, and the entry leaves the pool on the clock edge. Registers come back in one of two ways. A class-specific release port takes an index of its own class. A generic release port decides the class from the index range. The generic port silently discards the physical register that holds the hardwired integer zero register. It also discards the floating-point counterpart of that register when `FP_ZERO_EN` is set.

After reset, the first `INT_RSV` integer indices and the first `FP_RSV` floating-point indices are treated as already held by the initial architectural mappings. Each pool starts with its remaining indices in ascending order. Misuse sets one of two sticky error flags: allocating from an empty pool sets the underflow flag, and an illegal or unplaceable release sets the overflow flag.

Top module: `rename_free_list`

## Requirements
- R1: After reset, the integer count is `INT_PHYS-INT_RSV` and the integer head index is `INT_RSV`. The floating-point count is `FP_PHYS-FP_RSV` and the floating-point head index is `INT_PHYS+FP_RSV`. Both error flags are 0.
- R2: Each pool hands out its entries strictly in arrival order. The initial free indices come out in ascending order, and each released index comes out after all entries that were in the pool before it.
- R3: While a pool is non-empty, its head index is shown combinationally on the allocate index output, and the allocate valid output is 1. An allocate request removes the head on the clock edge and lowers the count by one. An integer allocation is always below `INT_PHYS`, and a floating-point allocation is always in `[INT_PHYS, INT_PHYS+FP_PHYS)`.
- R4: A generic release with an index below `INT_PHYS` enters the integer pool. A generic release with an index in `[INT_PHYS, INT_PHYS+FP_PHYS)` enters the floating-point pool.
- R5: A generic release of index `INT_ZERO` is dropped. A generic release of index `INT_PHYS+FP_ZERO_REL` is also dropped when `FP_ZERO_EN` is 1. In both cases no count changes and no error flag is set. Class-specific ports do not drop these indices.
- R6: An allocate request to an empty pool returns nothing: the valid output is 0 and the count stays at 0. The underflow flag becomes 1 from the next cycle and stays 1 until reset.
- R7: An allocate and a release on the same pool in the same cycle are both accepted. This holds even when the pool is full, and the count is unchanged. If the pool was empty, the released index is not shown on the allocate port in that cycle; it becomes the head afterwards.
- R8: The following releases are ignored and set the sticky overflow flag from the next cycle: a generic release with an index at or above `INT_PHYS+FP_PHYS`, a class-specific release whose index lies outside its class range, and a release into a full pool that has no allocation in the same cycle.
- R9: Each count output equals the number of entries in its pool and never exceeds the pool size. Each non-empty flag is 1 exactly when its count is non-zero.
- R10: A class-specific release and a generic release that reach the same pool in the same cycle are both accepted. The class-specific index is queued ahead of the generic one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_alloc_req | input | 1 | Take the integer head this cycle |
| int_alloc_idx | output | IDX_W | Integer head index |
| int_alloc_vld | output | 1 | Integer head index is valid |
| fp_alloc_req | input | 1 | Take the floating-point head this cycle |
| fp_alloc_idx | output | IDX_W | Floating-point head index |
| fp_alloc_vld | output | 1 | Floating-point head index is valid |
| int_rel_vld | input | 1 | Integer-class release strobe |
| int_rel_idx | input | IDX_W | Integer-class released index |
| fp_rel_vld | input | 1 | Floating-point-class release strobe |
| fp_rel_idx | input | IDX_W | Floating-point-class released index |
| any_rel_vld | input | 1 | Range-routed release strobe |
| any_rel_idx | input | IDX_W | Range-routed released index |
| int_free_cnt | output | clog2(INT_PHYS+1) | Free integer entries |
| int_nonempty | output | 1 | Integer pool holds an entry |
| fp_free_cnt | output | clog2(FP_PHYS+1) | Free floating-point entries |
| fp_nonempty | output | 1 | Floating-point pool holds an entry |
| underflow_err | output | 1 | Sticky: allocation from an empty pool |
| overflow_err | output | 1 | Sticky: rejected release |

IDX_W is clog2(INT_PHYS+FP_PHYS).

## Verification
The properties assume that reset is held for at least one clock edge before any request. They also assume that the surrounding logic never releases an index that is already in a pool. The pool cannot detect such a duplicate; it would simply queue it twice. The stimulus keeps to this: after each reset it releases only indices that are currently allocated or reserved. The one exception is the deliberate overflow tests, where the release is expected to be rejected by range or by fullness.

// File: rtl/rfl_pkg.sv
package rfl_pkg;

  // Advance a circular-buffer pointer over a depth that need not be a power of two.
  function automatic int wrap_next(input int p, input int depth);
    return (p >= depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/frl_pool.sv
module frl_pool #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 4,
  parameter int BASE  = 0,
  parameter int RSV   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop_req,
  output logic [IDX_W-1:0] head_idx,
  output logic             head_vld,
  input  logic             push_a,
  input  logic [IDX_W-1:0] idx_a,
  input  logic             push_b,
  input  logic [IDX_W-1:0] idx_b,
  output logic [$clog2(DEPTH+1)-1:0] occ_o,
  output logic             under_pls,
  output logic             reject_pls
);
  localparam int FREE0 = DEPTH - RSV;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0] rd_p, wr_p, wr_p1, wr_p2;
  logic [CNT_W-1:0] occ;
  logic [CNT_W:0]   room;
  logic             take, acc_a, acc_b;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return PTR_W'(rfl_pkg::wrap_next(int'(p), DEPTH));
  endfunction

  always_comb begin
    take  = pop_req && (occ != '0);
    room  = (CNT_W+1)'(DEPTH) - {1'b0, occ} + (CNT_W+1)'(take);
    acc_a = push_a && (room != '0);
    acc_b = push_b && (room > (CNT_W+1)'(acc_a));
    wr_p1 = bump(wr_p);
    wr_p2 = bump(wr_p1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        slots[i] <= (i < FREE0) ? IDX_W'(BASE + RSV + i) : '0;
      rd_p <= '0;
      wr_p <= PTR_W'(FREE0 % DEPTH);
      occ  <= CNT_W'(FREE0);
    end else begin
      if (acc_a) slots[wr_p] <= idx_a;
      if (acc_b) slots[acc_a ? wr_p1 : wr_p] <= idx_b;
      if (take) rd_p <= bump(rd_p);
      if (acc_a && acc_b)      wr_p <= wr_p2;
      else if (acc_a || acc_b) wr_p <= wr_p1;
      occ <= occ + CNT_W'(acc_a) + CNT_W'(acc_b) - CNT_W'(take);
    end
  end

  assign head_idx   = slots[rd_p];
  assign head_vld   = (occ != '0);
  assign occ_o      = occ;
  assign under_pls  = pop_req && (occ == '0);
  assign reject_pls = (push_a && !acc_a) || (push_b && !acc_b);
endmodule

// File: rtl/frl_route.sv
module frl_route #(
  parameter int INT_PHYS    = 8,
  parameter int FP_PHYS     = 6,
  parameter int IDX_W       = 4,
  parameter int INT_ZERO    = 0,
  parameter bit FP_ZERO_EN  = 1'b1,
  parameter int FP_ZERO_REL = 0
) (
  input  logic             int_rel_vld,
  input  logic [IDX_W-1:0] int_rel_idx,
  input  logic             fp_rel_vld,
  input  logic [IDX_W-1:0] fp_rel_idx,
  input  logic             any_rel_vld,
  input  logic [IDX_W-1:0] any_rel_idx,
  output logic             int_push_a,
  output logic             int_push_b,
  output logic             fp_push_a,
  output logic             fp_push_b,
  output logic             range_bad
);
  localparam int TOTAL = INT_PHYS + FP_PHYS;

  logic int_ok, fp_ok, g_int, g_fp, g_out, zero_i, zero_f;

  always_comb begin
    int_ok = int'(int_rel_idx) < INT_PHYS;
    fp_ok  = (int'(fp_rel_idx) >= INT_PHYS) && (int'(fp_rel_idx) < TOTAL);
    g_int  = int'(any_rel_idx) < INT_PHYS;
    g_fp   = (int'(any_rel_idx) >= INT_PHYS) && (int'(any_rel_idx) < TOTAL);
    g_out  = int'(any_rel_idx) >= TOTAL;
    zero_i = int'(any_rel_idx) == INT_ZERO;
  end

  generate
    if (FP_ZERO_EN) begin : g_fpz
      assign zero_f = int'(any_rel_idx) == INT_PHYS + FP_ZERO_REL;
    end else begin : g_nofpz
      assign zero_f = 1'b0;
    end
  endgenerate

  assign int_push_a = int_rel_vld && int_ok;
  assign fp_push_a  = fp_rel_vld && fp_ok;
  assign int_push_b = any_rel_vld && g_int && !zero_i;
  assign fp_push_b  = any_rel_vld && g_fp && !zero_f;
  assign range_bad  = (any_rel_vld && g_out) || (int_rel_vld && !int_ok)
                   || (fp_rel_vld && !fp_ok);
endmodule

// File: rtl/frl_sticky.sv
module frl_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/rename_free_list.sv
module rename_free_list #(
  parameter int INT_PHYS    = 8,
  parameter int FP_PHYS     = 6,
  parameter int INT_RSV     = 4,
  parameter int FP_RSV      = 3,
  parameter int INT_ZERO    = 0,
  parameter bit FP_ZERO_EN  = 1'b1,
  parameter int FP_ZERO_REL = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic int_alloc_req,
  output logic [$clog2(INT_PHYS+FP_PHYS)-1:0] int_alloc_idx,
  output logic int_alloc_vld,
  input  logic fp_alloc_req,
  output logic [$clog2(INT_PHYS+FP_PHYS)-1:0] fp_alloc_idx,
  output logic fp_alloc_vld,
  input  logic int_rel_vld,
  input  logic [$clog2(INT_PHYS+FP_PHYS)-1:0] int_rel_idx,
  input  logic fp_rel_vld,
  input  logic [$clog2(INT_PHYS+FP_PHYS)-1:0] fp_rel_idx,
  input  logic any_rel_vld,
  input  logic [$clog2(INT_PHYS+FP_PHYS)-1:0] any_rel_idx,
  output logic [$clog2(INT_PHYS+1)-1:0] int_free_cnt,
  output logic int_nonempty,
  output logic [$clog2(FP_PHYS+1)-1:0] fp_free_cnt,
  output logic fp_nonempty,
  output logic underflow_err,
  output logic overflow_err
);
  localparam int IDX_W = $clog2(INT_PHYS + FP_PHYS);

  logic int_pa, int_pb, fp_pa, fp_pb, range_bad;
  logic int_under, fp_under, int_rej, fp_rej;
  logic [1:0] err_set, err_flag;

  frl_route #(
    .INT_PHYS(INT_PHYS), .FP_PHYS(FP_PHYS), .IDX_W(IDX_W),
    .INT_ZERO(INT_ZERO), .FP_ZERO_EN(FP_ZERO_EN), .FP_ZERO_REL(FP_ZERO_REL)
  ) u_route (
    .int_rel_vld(int_rel_vld), .int_rel_idx(int_rel_idx),
    .fp_rel_vld(fp_rel_vld),   .fp_rel_idx(fp_rel_idx),
    .any_rel_vld(any_rel_vld), .any_rel_idx(any_rel_idx),
    .int_push_a(int_pa), .int_push_b(int_pb),
    .fp_push_a(fp_pa),   .fp_push_b(fp_pb),
    .range_bad(range_bad)
  );

  frl_pool #(.DEPTH(INT_PHYS), .IDX_W(IDX_W), .BASE(0), .RSV(INT_RSV)) u_int_pool (
    .clk(clk), .rst(rst), .pop_req(int_alloc_req),
    .head_idx(int_alloc_idx), .head_vld(int_alloc_vld),
    .push_a(int_pa), .idx_a(int_rel_idx),
    .push_b(int_pb), .idx_b(any_rel_idx),
    .occ_o(int_free_cnt), .under_pls(int_under), .reject_pls(int_rej)
  );

  frl_pool #(.DEPTH(FP_PHYS), .IDX_W(IDX_W), .BASE(INT_PHYS), .RSV(FP_RSV)) u_fp_pool (
    .clk(clk), .rst(rst), .pop_req(fp_alloc_req),
    .head_idx(fp_alloc_idx), .head_vld(fp_alloc_vld),
    .push_a(fp_pa), .idx_a(fp_rel_idx),
    .push_b(fp_pb), .idx_b(any_rel_idx),
    .occ_o(fp_free_cnt), .under_pls(fp_under), .reject_pls(fp_rej)
  );

  assign err_set = {int_rej || fp_rej || range_bad, int_under || fp_under};

  frl_sticky #(.N(2)) u_err (
    .clk(clk), .rst(rst), .set_i(err_set), .flag_o(err_flag)
  );

  assign underflow_err = err_flag[0];
  assign overflow_err  = err_flag[1];
  assign int_nonempty  = int_alloc_vld;
  assign fp_nonempty   = fp_alloc_vld;
endmodule

// File: rtl/rename_free_list_chk.sv
module rename_free_list_chk #(
  parameter int INT_PHYS = 8,
  parameter int FP_PHYS  = 6,
  parameter int INT_ZERO = 0
) (
  input logic clk,
  input logic rst,
  input logic int_alloc_req,
  input logic int_alloc_vld,
  input logic [$clog2(INT_PHYS+FP_PHYS)-1:0] int_alloc_idx,
  input logic fp_alloc_vld,
  input logic [$clog2(INT_PHYS+FP_PHYS)-1:0] fp_alloc_idx,
  input logic int_rel_vld,
  input logic any_rel_vld,
  input logic [$clog2(INT_PHYS+FP_PHYS)-1:0] any_rel_idx,
  input logic [$clog2(INT_PHYS+1)-1:0] int_free_cnt,
  input logic int_nonempty,
  input logic [$clog2(FP_PHYS+1)-1:0] fp_free_cnt,
  input logic underflow_err,
  input logic overflow_err
);
  localparam int TOTAL = INT_PHYS + FP_PHYS;

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(int_free_cnt) <= INT_PHYS) && (int'(fp_free_cnt) <= FP_PHYS));

  // R3
  int_class_chk: assert property (@(posedge clk) disable iff (rst)
    int_alloc_vld |-> int'(int_alloc_idx) < INT_PHYS);

  // R3
  fp_class_chk: assert property (@(posedge clk) disable iff (rst)
    fp_alloc_vld |-> (int'(fp_alloc_idx) >= INT_PHYS) && (int'(fp_alloc_idx) < TOTAL));

  // R3
  int_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (int_alloc_req && int_nonempty && !int_rel_vld && !any_rel_vld)
      |=> int_free_cnt == $past(int_free_cnt) - 1'b1);

  // R6
  underflow_set_chk: assert property (@(posedge clk) disable iff (rst)
    (int_alloc_req && !int_nonempty) |=> underflow_err);

  // R6
  underflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    underflow_err |=> underflow_err);

  // R8
  overflow_range_chk: assert property (@(posedge clk) disable iff (rst)
    (any_rel_vld && int'(any_rel_idx) >= TOTAL) |=> overflow_err);

  // R5
  zero_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (any_rel_vld && int'(any_rel_idx) == INT_ZERO && !int_alloc_req && !int_rel_vld)
      |=> int_free_cnt == $past(int_free_cnt));
endmodule

bind rename_free_list rename_free_list_chk #(
  .INT_PHYS(INT_PHYS), .FP_PHYS(FP_PHYS), .INT_ZERO(INT_ZERO)
) u_chk (
  .clk(clk), .rst(rst),
  .int_alloc_req(int_alloc_req), .int_alloc_vld(int_alloc_vld),
  .int_alloc_idx(int_alloc_idx),
  .fp_alloc_vld(fp_alloc_vld), .fp_alloc_idx(fp_alloc_idx),
  .int_rel_vld(int_rel_vld), .any_rel_vld(any_rel_vld),
  .any_rel_idx(any_rel_idx),
  .int_free_cnt(int_free_cnt), .int_nonempty(int_nonempty),
  .fp_free_cnt(fp_free_cnt),
  .underflow_err(underflow_err), .overflow_err(overflow_err)
);

// File: tb/rename_free_list_test.sv
`timescale 1ns/1ps
module rename_free_list_test;
  localparam int INT_PHYS = 8;
  localparam int FP_PHYS  = 6;
  localparam int INT_RSV  = 4;
  localparam int FP_RSV   = 3;
  localparam int IW       = 4;
  localparam int NROW     = 10;

  // row: {ir, fr, iv, ii[4], fv, fi[4], gv, gi[4], exp_int_cnt[4], exp_fp_cnt[4]}
  localparam logic [24:0] TBL [NROW] = '{
    {1'b1,1'b0, 1'b0,4'd0,  1'b0,4'd0,  1'b0,4'd0,  4'd3,4'd3},
    {1'b0,1'b1, 1'b0,4'd0,  1'b0,4'd0,  1'b0,4'd0,  4'd3,4'd2},
    {1'b0,1'b0, 1'b1,4'd2,  1'b0,4'd0,  1'b0,4'd0,  4'd4,4'd2},
    {1'b0,1'b0, 1'b0,4'd0,  1'b0,4'd0,  1'b1,4'd9,  4'd4,4'd3},
    {1'b0,1'b0, 1'b0,4'd0,  1'b0,4'd0,  1'b1,4'd3,  4'd5,4'd3},
    {1'b1,1'b0, 1'b1,4'd1,  1'b0,4'd0,  1'b0,4'd0,  4'd5,4'd3},
    {1'b0,1'b1, 1'b0,4'd0,  1'b1,4'd10, 1'b1,4'd11, 4'd5,4'd4},
    {1'b0,1'b0, 1'b0,4'd0,  1'b0,4'd0,  1'b1,4'd0,  4'd5,4'd4},
    {1'b0,1'b0, 1'b0,4'd0,  1'b0,4'd0,  1'b1,4'd8,  4'd5,4'd4},
    {1'b1,1'b1, 1'b0,4'd0,  1'b0,4'd0,  1'b0,4'd0,  4'd4,4'd3}
  };

  logic clk = 1'b0, rst;
  logic int_alloc_req, fp_alloc_req, int_rel_vld, fp_rel_vld, any_rel_vld;
  logic [IW-1:0] int_alloc_idx, fp_alloc_idx, int_rel_idx, fp_rel_idx, any_rel_idx;
  logic int_alloc_vld, fp_alloc_vld, int_nonempty, fp_nonempty;
  logic underflow_err, overflow_err;
  logic [3:0] int_free_cnt;
  logic [2:0] fp_free_cnt;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int mi[$];
  int mf[$];

  always #2.5 clk = ~clk;

  rename_free_list uut (
    .clk(clk), .rst(rst),
    .int_alloc_req(int_alloc_req), .int_alloc_idx(int_alloc_idx), .int_alloc_vld(int_alloc_vld),
    .fp_alloc_req(fp_alloc_req), .fp_alloc_idx(fp_alloc_idx), .fp_alloc_vld(fp_alloc_vld),
    .int_rel_vld(int_rel_vld), .int_rel_idx(int_rel_idx),
    .fp_rel_vld(fp_rel_vld), .fp_rel_idx(fp_rel_idx),
    .any_rel_vld(any_rel_vld), .any_rel_idx(any_rel_idx),
    .int_free_cnt(int_free_cnt), .int_nonempty(int_nonempty),
    .fp_free_cnt(fp_free_cnt), .fp_nonempty(fp_nonempty),
    .underflow_err(underflow_err), .overflow_err(overflow_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drv(input bit ir, input bit fr, input bit iv, input int ii,
                     input bit fv, input int fi, input bit gv, input int gi);
    int_alloc_req = ir; fp_alloc_req = fr;
    int_rel_vld = iv; int_rel_idx = IW'(ii);
    fp_rel_vld = fv;  fp_rel_idx = IW'(fi);
    any_rel_vld = gv; any_rel_idx = IW'(gi);
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    drv(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drv(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic chk_reset_state();
    chk("R1 int count", int'(int_free_cnt), INT_PHYS - INT_RSV);
    chk("R1 int head", int'(int_alloc_idx), INT_RSV);
    chk("R1 fp count", int'(fp_free_cnt), FP_PHYS - FP_RSV);
    chk("R1 fp head", int'(fp_alloc_idx), INT_PHYS + FP_RSV);
    chk("R1 underflow", int'(underflow_err), 0);
    chk("R1 overflow", int'(overflow_err), 0);
  endtask

  initial begin
    #(20000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk_reset_state();
    chk("R9 int nonempty at reset", int'(int_nonempty), 1);
    for (int i = INT_RSV; i < INT_PHYS; i++) mi.push_back(i);
    for (int i = INT_PHYS + FP_RSV; i < INT_PHYS + FP_PHYS; i++) mf.push_back(i);

    // table walk: model queues give the expected head, the row gives the counts
    for (int k = 0; k < NROW; k++) begin
      logic [24:0] r;
      r = TBL[k];
      drv(r[24], r[23], r[22], int'(r[21:18]), r[17], int'(r[16:13]), r[12], int'(r[11:8]));
      if (r[24]) chk("R2 R3 int alloc idx", int'(int_alloc_idx), mi[0]);
      if (r[23]) chk("R2 R3 fp alloc idx", int'(fp_alloc_idx), mf[0]);
      if (r[24]) void'(mi.pop_front());
      if (r[23]) void'(mf.pop_front());
      if (r[22]) mi.push_back(int'(r[21:18]));
      if (r[17]) mf.push_back(int'(r[16:13]));
      if (r[12]) begin
        int g;
        g = int'(r[11:8]);
        if (g < INT_PHYS && g != 0) mi.push_back(g);
        else if (g >= INT_PHYS && g < INT_PHYS + FP_PHYS && g != INT_PHYS) mf.push_back(g);
      end
      tick();
      chk("R4 R5 R10 int count", int'(int_free_cnt), int'(r[7:4]));
      chk("R4 R5 R10 fp count", int'(fp_free_cnt), int'(r[3:0]));
      chk("R9 int nonempty", int'(int_nonempty), int'(int_free_cnt != 0));
    end
    chk("R2 int head after table", int'(int_alloc_idx), mi[0]);
    chk("R2 fp head after table", int'(fp_alloc_idx), mf[0]);
    chk("R5 no error from zero drop", int'(overflow_err), 0);

    // drain floating-point pool (9, 10, 11)
    for (int k = 0; k < 3; k++) begin
      drv(0, 1, 0, 0, 0, 0, 0, 0);
      chk("R2 fp drain order", int'(fp_alloc_idx), 9 + k);
      tick();
    end
    chk("R9 fp empty count", int'(fp_free_cnt), 0);
    chk("R9 fp nonempty low", int'(fp_nonempty), 0);
    chk("R6 fp vld low when empty", int'(fp_alloc_vld), 0);

    // allocate and release together on an empty pool
    drv(0, 1, 0, 0, 1, 12, 0, 0);
    chk("R7 no bypass when empty", int'(fp_alloc_vld), 0);
    tick();
    chk("R6 underflow set", int'(underflow_err), 1);
    chk("R7 release kept", int'(fp_free_cnt), 1);
    chk("R7 released becomes head", int'(fp_alloc_idx), 12);
    chk("R6 overflow untouched", int'(overflow_err), 0);
    tick();
    chk("R6 underflow sticky", int'(underflow_err), 1);

    // out-of-range generic release
    drv(0, 0, 0, 0, 0, 0, 1, 14);
    tick();
    chk("R8 overflow on range", int'(overflow_err), 1);
    chk("R8 int count unchanged", int'(int_free_cnt), 4);
    chk("R8 fp count unchanged", int'(fp_free_cnt), 1);

    do_reset();
    chk_reset_state();

    // wrong-class release on the integer port
    drv(0, 0, 1, 9, 0, 0, 0, 0);
    tick();
    chk("R8 overflow on wrong class", int'(overflow_err), 1);
    chk("R8 int count after wrong class", int'(int_free_cnt), 4);
    chk("R8 fp count after wrong class", int'(fp_free_cnt), 3);

    do_reset();
    // fill integer pool with paired releases; index 0 via the class port is kept
    drv(0, 0, 1, 0, 0, 0, 1, 1);
    tick();
    chk("R10 dual push count", int'(int_free_cnt), 6);
    drv(0, 0, 1, 2, 0, 0, 1, 3);
    tick();
    chk("R9 int full count", int'(int_free_cnt), 8);
    // allocate and release together while full
    drv(1, 0, 1, 4, 0, 0, 0, 0);
    chk("R3 head while full", int'(int_alloc_idx), 4);
    tick();
    chk("R7 full pop+push count", int'(int_free_cnt), 8);
    chk("R7 no overflow when popping", int'(overflow_err), 0);
    // release into a full pool
    drv(0, 0, 1, 5, 0, 0, 0, 0);
    tick();
    chk("R8 overflow on full", int'(overflow_err), 1);
    chk("R8 full count held", int'(int_free_cnt), 8);
    // order check after fill: 5, 6, 7, 0, 1, 2, 3, 4
    drv(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 R2 order after fill", int'(int_alloc_idx), 5);
    tick();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule